// File: doc/BRIEF.md
# Programmable 16x Baud Enable Generator

This block turns one master clock into a serial-timing enable. A 16-bit divisor sets the rate. Every `divisor` master-clock cycles the block raises `tick16` for exactly one cycle. The strobe runs at sixteen times the serial bit rate, so the bit rate is f_clk / (divisor × 16). Transmit and receive logic stays on the master clock and acts only on cycles where the strobe is high. No derived clock exists, and clocks up to 24 MHz need no special handling.

A second strobe, `tick1`, marks every sixteenth `tick16` pulse and gives a bit-rate enable directly. A divisor write takes effect at once and restarts the period. A write of zero is treated as one.

Top module: `baud_strobe_gen`

## Requirements
- R1: While `rst` is high at a rising edge, both strobes are low in the following cycle and the divisor becomes RST_DIV (default 1). The first `tick16` after reset comes on the RST_DIV-th rising edge after the last reset edge.
- R2: With divisor D loaded, `tick16` is high for exactly one cycle out of every D cycles, and consecutive pulses are D cycles apart.
- R3: With D = 1, `tick16` is high on every cycle.
- R4: A written divisor of 0 behaves exactly like a divisor of 1.
- R5: After a rising edge with `div_wr` high, `tick16` is low in the next cycle. The next pulse comes on the D-th edge after the write edge, where D is the written value.
- R6: `tick1` is high only in cycles where `tick16` is high. It pulses on the 16th, 32nd, … `tick16` pulse counted from reset, and divisor writes do not restart that count.
- R7: The largest divisor, 65535, gives a strobe period of exactly 65535 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| div_in | input | 16 | Divisor value to load |
| div_wr | input | 1 | Load `div_in` into the divisor register on this edge |
| tick16 | output | 1 | One-cycle enable at 16x the bit rate |
| tick1 | output | 1 | One-cycle enable at the bit rate (every 16th `tick16`) |

## Verification
A wrong down-counter value shows as a `tick16` pulse arriving early or late. The error appears on the first period after the fault, so it is visible within D cycles. A wrong divisor register leaves every later period at the wrong length. A bit-counter fault moves or drops the `tick1` pulse, which is visible within sixteen `tick16` periods. The bench compares both strobes with a cycle model on every cycle. A misplaced pulse is therefore caught in the cycle it occurs.

// File: rtl/baud_pkg.sv
package baud_pkg;
   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/baud_div_reg.sv
module baud_div_reg #(
   parameter int DIV_W   = 16,
   parameter int RST_DIV = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DIV_W-1:0] div_in,
   input  logic             div_wr,
   output logic [DIV_W-1:0] div_q,
   output logic [DIV_W-1:0] div_new
);
   localparam logic [DIV_W-1:0] RST_VAL = DIV_W'(RST_DIV);

   // zero is mapped to one so the counter never sees an empty period
   assign div_new = (div_in == '0) ? DIV_W'(1) : div_in;

   always_ff @(posedge clk) begin
      if (rst)         div_q <= RST_VAL;
      else if (div_wr) div_q <= div_new;
   end

   p_div_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
      div_q != '0);
endmodule

// File: rtl/baud_div_counter.sv
module baud_div_counter #(
   parameter int DIV_W   = 16,
   parameter int RST_DIV = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             div_wr,
   input  logic [DIV_W-1:0] div_q,
   input  logic [DIV_W-1:0] div_new,
   output logic             fire,
   output logic             tick16
);
   localparam logic [DIV_W-1:0] RST_CNT = DIV_W'(RST_DIV - 1);

   logic [DIV_W-1:0] cnt;

   assign fire = !rst && !div_wr && (cnt == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt    <= RST_CNT;
         tick16 <= 1'b0;
      end else if (div_wr) begin
         cnt    <= div_new - DIV_W'(1);
         tick16 <= 1'b0;
      end else if (cnt == '0) begin
         cnt    <= div_q - DIV_W'(1);
         tick16 <= 1'b1;
      end else begin
         cnt    <= cnt - DIV_W'(1);
         tick16 <= 1'b0;
      end
   end

   p_reset_quiet_r1: assert property (@(posedge clk)
      rst |=> !tick16);
   p_write_quiet_r5: assert property (@(posedge clk) disable iff (rst)
      div_wr |=> !tick16);
   p_cnt_in_period_r2: assert property (@(posedge clk) disable iff (rst)
      cnt < div_q);
   p_reload_r2: assert property (@(posedge clk) disable iff (rst)
      fire |=> (tick16 && (cnt == div_q - DIV_W'(1))));
endmodule

// File: rtl/baud_bit_counter.sv
module baud_bit_counter #(
   parameter int OVS = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic fire,
   output logic tick1
);
   localparam int OVS_W = $clog2(OVS);
   localparam logic [OVS_W-1:0] LAST = OVS_W'(OVS - 1);

   logic [OVS_W-1:0] bc;

   always_ff @(posedge clk) begin
      if (rst) begin
         bc    <= '0;
         tick1 <= 1'b0;
      end else if (fire) begin
         bc    <= bc + OVS_W'(1);
         tick1 <= (bc == LAST);
      end else begin
         tick1 <= 1'b0;
      end
   end

   p_bit_wrap_r6: assert property (@(posedge clk) disable iff (rst)
      (fire && bc == LAST) |=> (tick1 && bc == '0));
endmodule

// File: rtl/baud_strobe_gen.sv
module baud_strobe_gen #(
   parameter int DIV_W          = 16,
   parameter int OVS            = 16,
   parameter int RST_DIV        = 1,
   parameter bit HAS_BIT_STROBE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DIV_W-1:0] div_in,
   input  logic             div_wr,
   output logic             tick16,
   output logic             tick1
);
   import baud_pkg::*;

   if (DIV_W < 2 || DIV_W > 31) begin : g_bad_width
      $error("DIV_W out of range");
   end
   if (!is_pow2(OVS) || OVS < 2) begin : g_bad_ovs
      $error("OVS must be a power of two of at least 2");
   end
   if (RST_DIV < 1 || RST_DIV >= (1 << DIV_W)) begin : g_bad_rst
      $error("RST_DIV out of range");
   end

   logic [DIV_W-1:0] div_q, div_new;
   logic             fire;

   baud_div_reg #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_reg (
      .clk(clk), .rst(rst), .div_in(div_in), .div_wr(div_wr),
      .div_q(div_q), .div_new(div_new));

   baud_div_counter #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_cnt (
      .clk(clk), .rst(rst), .div_wr(div_wr), .div_q(div_q),
      .div_new(div_new), .fire(fire), .tick16(tick16));

   if (HAS_BIT_STROBE) begin : g_bit
      baud_bit_counter #(.OVS(OVS)) u_bit (
         .clk(clk), .rst(rst), .fire(fire), .tick1(tick1));
   end else begin : g_no_bit
      assign tick1 = 1'b0;
   end

   p_bit_with_fast_r6: assert property (@(posedge clk) disable iff (rst)
      tick1 |-> tick16);
   p_reset_bit_quiet_r1: assert property (@(posedge clk)
      rst |=> !tick1);
endmodule

// File: tb/sim_baud_strobe_gen.sv
module sim_baud_strobe_gen;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] div_in = '0;
   logic        div_wr = 1'b0;
   logic        tick16, tick1;

   int unsigned n_chk = 0, n_fail = 0, cycles = 0;
   string       cur_req = "R1";

   // reference model state
   int unsigned m_div = 1, m_ph = 0, m_n16 = 0;
   bit          e16 = 0, e1 = 0;

   always #2 clk = ~clk;

   baud_strobe_gen u0 (.clk(clk), .rst(rst), .div_in(div_in), .div_wr(div_wr),
                       .tick16(tick16), .tick1(tick1));

   function automatic int unsigned eff(input int unsigned d);
      return (d == 0) ? 1 : d;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_div = 1; m_ph = 0; m_n16 = 0; e16 = 0; e1 = 0;
      end else if (div_wr) begin
         m_div = eff(div_in); m_ph = 0; e16 = 0; e1 = 0;
      end else begin
         m_ph++;
         if (m_ph == m_div) begin
            m_ph = 0; e16 = 1; m_n16++;
            e1 = (m_n16 % 16 == 0);
         end else begin
            e16 = 0; e1 = 0;
         end
      end
   end

   task automatic check(input string req, input bit act, input bit exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", req, what, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      check(cur_req, tick16, e16, "tick16");
      check((cur_req == "R1") ? "R1" : "R6", tick1, e1, "tick1");
   end

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int unsigned d);
      @(negedge clk); div_in = 16'(d); div_wr = 1'b1;
      @(negedge clk); div_wr = 1'b0;
   endtask

   task automatic finish_up;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(4 * 190000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_up();
   end

   initial begin
      void'($urandom(32'd4242));
      run(3);
      @(negedge clk); rst = 1'b0;
      run(20);                       // R1, R3: default divisor 1 strobes every cycle
      cur_req = "R2"; wr(5);   run(100);
      cur_req = "R4"; wr(0);   run(40);
      cur_req = "R3"; wr(1);   run(40);
      cur_req = "R5"; wr(7); run(3); wr(3); run(2); wr(9); run(50);
      cur_req = "R1"; @(negedge clk); rst = 1'b1; run(2); @(negedge clk); rst = 1'b0;
      run(10);
      cur_req = "R2";
      for (int i = 0; i < 60; i++) begin
         int unsigned d;
         d = $urandom_range(0, 40);
         if ($urandom_range(0, 9) == 0) d = $urandom_range(100, 400);
         wr(d);
         run($urandom_range(1, 3 * eff(d) + 20));
      end
      cur_req = "R7"; wr(65535); run(65535 + 40);
      cur_req = "R6"; wr(2); run(200);
      finish_up();
   end
endmodule